// File: doc/BRIEF.md
# Exception Priority Arbiter

This block sits beside the front end of a small processor core and decides which exception the core takes next. Each cycle it looks at seven raw request lines: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. It gates the two interrupt lines with mask bits held in an 8-bit control byte and selects the winner by a fixed priority. In the cycle after a request is accepted, it presents a registered one-hot grant, a mode code and the vector address, together with a one-cycle take strobe.

The vector address is a base plus a fixed offset for each exception. The base is either address zero or the high base 0xFFFF0000, chosen by a control input that is sampled in the arbitration cycle. When an exception is taken, the block raises the interrupt mask bits in its control byte, so a normal interrupt that is still requested cannot be taken again straight away. Software can load the whole control byte through a write port, for example to restore the mask bits on return from a handler.

Top module: `exc_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released, take is 0, grant is 0, modeCode is 0, vector is 0 and ctrlOut is 8'hC0, until the first accepted request.
- R2: When several effective requests are active in the same cycle, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R3: ctrlOut bit 7 set to 1 blocks reqIrq and bit 6 set to 1 blocks reqFiq; a value of 0 lets the request through. The bits are sampled in the arbitration cycle.
- R4: Grant bit positions are: 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 normal interrupt, 6 fast interrupt. vector[7:0] carries the offset 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 or 0x1C in that same order.
- R5: vector[31:16] is 0x0000 when hiVectors was low in the arbitration cycle and 0xFFFF when it was high.
- R6: modeCode is 1 for a fast interrupt, 2 for a normal interrupt, 3 for reset and software interrupt, 4 for either abort and 5 for an undefined instruction.
- R7: If reqUndef and reqSwi are both active with nothing of higher priority, undefined instruction wins.
- R8: Taking reset or a fast interrupt sets ctrlOut bits 7 and 6. Taking any other exception sets bit 7 and leaves bit 6 as it was. No take alters bits 5 to 0.
- R9: take is 1 for exactly one cycle, in the cycle after each cycle that has an effective request. When take is 0, grant, modeCode and vector keep their previous values.
- R10: With ctrlWrEn high, ctrlWrData is loaded into the control byte at the clock edge, and any mask bits set by a take in the same cycle are ORed on top. Arbitration in that cycle uses the control byte as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqReset | input | 1 | Reset exception request |
| reqUndef | input | 1 | Undefined-instruction request |
| reqSwi | input | 1 | Software-interrupt request |
| reqPrefetchAbort | input | 1 | Prefetch-abort request |
| reqDataAbort | input | 1 | Data-abort request |
| reqIrq | input | 1 | Normal interrupt request |
| reqFiq | input | 1 | Fast interrupt request |
| hiVectors | input | 1 | Selects the high vector base 0xFFFF0000 |
| ctrlWrEn | input | 1 | Loads the control byte |
| ctrlWrData | input | 8 | New control byte value |
| take | output | 1 | One-cycle pulse for each accepted exception |
| grant | output | 7 | One-hot grant of the accepted exception |
| modeCode | output | 3 | Mode entered for the accepted exception |
| vector | output | 32 | Vector address of the accepted exception |
| ctrlOut | output | 8 | Current control byte; bits 7 and 6 are the interrupt masks |

## Verification
The assertions assume the request lines change only between clock edges and are held stable across each edge. They also assume a request is meant to be counted once for every cycle it is held, so a requester that wants a single take drops its line after one cycle. The bench drives every input at the falling edge and holds each request pattern for exactly one cycle, with idle cycles around it. The one deliberate exception is the held interrupt case, which checks that the mask set on entry blocks a repeat take.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

  localparam int NUM_EXC = 7;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_IRQ   = 3'd5,
    EXC_FIQ   = 3'd6
  } excKind_t;

  typedef enum logic [2:0] {
    MODE_NONE   = 3'd0,
    MODE_FAST   = 3'd1,
    MODE_NORMAL = 3'd2,
    MODE_SUPER  = 3'd3,
    MODE_ABORT  = 3'd4,
    MODE_UNDEF  = 3'd5
  } mode_t;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic     take;
    excKind_t kind;
    logic     setIrqMask;
    logic     setFiqMask;
  } ctrlStrobe_t;

  function automatic logic [4:0] vecOffset(excKind_t k);
    case (k)
      EXC_RESET: return 5'h00;
      EXC_UNDEF: return 5'h04;
      EXC_SWI:   return 5'h08;
      EXC_PABT:  return 5'h0C;
      EXC_DABT:  return 5'h10;
      EXC_IRQ:   return 5'h18;
      default:   return 5'h1C;
    endcase
  endfunction

  function automatic mode_t kindMode(excKind_t k);
    case (k)
      EXC_FIQ:            return MODE_FAST;
      EXC_IRQ:            return MODE_NORMAL;
      EXC_PABT, EXC_DABT: return MODE_ABORT;
      EXC_UNDEF:          return MODE_UNDEF;
      default:            return MODE_SUPER;
    endcase
  endfunction

endpackage

// File: rtl/exc_arb_ctrl.sv
module exc_arb_ctrl
  import exc_arb_pkg::*;
(
  input  logic [NUM_EXC-1:0] reqVec,
  input  logic               irqMasked,
  input  logic               fiqMasked,
  output ctrlStrobe_t        strobe
);

  // Highest priority first
  localparam excKind_t PRIO [NUM_EXC] = '{
    EXC_RESET, EXC_DABT, EXC_FIQ, EXC_IRQ, EXC_PABT, EXC_UNDEF, EXC_SWI
  };

  logic [NUM_EXC-1:0] effReq;

  always_comb begin
    effReq = reqVec;
    effReq[EXC_IRQ] = reqVec[EXC_IRQ] & ~irqMasked;
    effReq[EXC_FIQ] = reqVec[EXC_FIQ] & ~fiqMasked;
  end

  always_comb begin
    strobe = '{take: 1'b0, kind: EXC_RESET, setIrqMask: 1'b0, setFiqMask: 1'b0};
    // Walk from lowest to highest so the highest active entry wins
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (effReq[PRIO[i]]) begin
        strobe.take = 1'b1;
        strobe.kind = PRIO[i];
      end
    end
    strobe.setIrqMask = strobe.take;
    strobe.setFiqMask = strobe.take &&
                        (strobe.kind == EXC_RESET || strobe.kind == EXC_FIQ);
  end

endmodule

// File: rtl/exc_arb_dp.sv
module exc_arb_dp
  import exc_arb_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          CTRL_W     = 8,
  parameter int          IRQ_BIT    = 7,
  parameter int          FIQ_BIT    = 6,
  parameter logic [31:0] HIGH_BASE  = 32'hFFFF_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               hiVectors,
  input  logic               ctrlWrEn,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  output logic               take,
  output logic [NUM_EXC-1:0] grant,
  output logic [2:0]         modeCode,
  output logic [ADDR_W-1:0]  vector,
  output logic [CTRL_W-1:0]  ctrlQ
);

  localparam logic [CTRL_W-1:0] CTRL_RESET =
    (CTRL_W'(1) << IRQ_BIT) | (CTRL_W'(1) << FIQ_BIT);
  localparam logic [ADDR_W-1:0] BASE_HI = ADDR_W'(HIGH_BASE);

  logic [CTRL_W-1:0]  ctrlNext;
  logic [NUM_EXC-1:0] grantNext;
  logic [ADDR_W-1:0]  vectorNext;

  always_comb begin
    ctrlNext = ctrlWrEn ? ctrlWrData : ctrlQ;
    if (strobe.setIrqMask) ctrlNext[IRQ_BIT] = 1'b1;
    if (strobe.setFiqMask) ctrlNext[FIQ_BIT] = 1'b1;
  end

  always_comb begin
    grantNext  = NUM_EXC'(1) << strobe.kind;
    vectorNext = (hiVectors ? BASE_HI : '0) | ADDR_W'(vecOffset(strobe.kind));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= CTRL_RESET;
      take     <= 1'b0;
      grant    <= '0;
      modeCode <= MODE_NONE;
      vector   <= '0;
    end else begin
      ctrlQ <= ctrlNext;
      take  <= strobe.take;
      if (strobe.take) begin
        grant    <= grantNext;
        modeCode <= kindMode(strobe.kind);
        vector   <= vectorNext;
      end
    end
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          CTRL_W    = 8,
  parameter int          IRQ_BIT   = 7,
  parameter int          FIQ_BIT   = 6,
  parameter logic [31:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqReset,
  input  logic               reqUndef,
  input  logic               reqSwi,
  input  logic               reqPrefetchAbort,
  input  logic               reqDataAbort,
  input  logic               reqIrq,
  input  logic               reqFiq,
  input  logic               hiVectors,
  input  logic               ctrlWrEn,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  output logic               take,
  output logic [NUM_EXC-1:0] grant,
  output logic [2:0]         modeCode,
  output logic [ADDR_W-1:0]  vector,
  output logic [CTRL_W-1:0]  ctrlOut
);

  logic [NUM_EXC-1:0] reqVec;
  ctrlStrobe_t        strobe;

  assign reqVec = {reqFiq, reqIrq, reqDataAbort, reqPrefetchAbort,
                   reqSwi, reqUndef, reqReset};

  exc_arb_ctrl u_ctrl (
    .reqVec    (reqVec),
    .irqMasked (ctrlOut[IRQ_BIT]),
    .fiqMasked (ctrlOut[FIQ_BIT]),
    .strobe    (strobe)
  );

  exc_arb_dp #(
    .ADDR_W    (ADDR_W),
    .CTRL_W    (CTRL_W),
    .IRQ_BIT   (IRQ_BIT),
    .FIQ_BIT   (FIQ_BIT),
    .HIGH_BASE (HIGH_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hiVectors  (hiVectors),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .take       (take),
    .grant      (grant),
    .modeCode   (modeCode),
    .vector     (vector),
    .ctrlQ      (ctrlOut)
  );

endmodule

// File: rtl/exc_arb_checker.sv
module exc_arb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqReset,
  input logic        reqUndef,
  input logic        reqSwi,
  input logic        reqPrefetchAbort,
  input logic        reqDataAbort,
  input logic        reqIrq,
  input logic        reqFiq,
  input logic        hiVectors,
  input logic        ctrlWrEn,
  input logic        take,
  input logic [6:0]  grant,
  input logic [31:0] vector,
  input logic [7:0]  ctrlOut
);

  logic anyReq;
  assign anyReq = reqReset | reqUndef | reqSwi | reqPrefetchAbort |
                  reqDataAbort | reqIrq | reqFiq;

  assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    take && $past(reqReset) |-> grant[0]);

  assert_dabt_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    take && $past(reqDataAbort) && !$past(reqReset) |-> grant[4]);

  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    take && grant[5] |-> !$past(ctrlOut[7]));

  assert_fiq_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    take && grant[6] |-> !$past(ctrlOut[6]));

  assert_vec_base_R5: assert property (@(posedge clk) disable iff (!rstN)
    take |-> vector[31:16] == ($past(hiVectors) ? 16'hFFFF : 16'h0000));

  assert_undef_over_swi_R7: assert property (@(posedge clk) disable iff (!rstN)
    take && $past(reqUndef) && $past(reqSwi) |-> !grant[2]);

  assert_irq_mask_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    take |-> ctrlOut[7]);

  assert_fiq_mask_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    take && (grant[0] || grant[6]) |-> ctrlOut[6]);

  assert_fiq_mask_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    take && !grant[0] && !grant[6] && !$past(ctrlWrEn) |->
      ctrlOut[6] == $past(ctrlOut[6]));

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    take |-> $countones(grant) == 1);

  assert_take_needs_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    take |-> $past(anyReq));

  assert_grant_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    !take |-> $stable(grant) && $stable(vector));

endmodule

bind exc_arbiter exc_arb_checker u_exc_arb_checker (
  .clk              (clk),
  .rstN             (rstN),
  .reqReset         (reqReset),
  .reqUndef         (reqUndef),
  .reqSwi           (reqSwi),
  .reqPrefetchAbort (reqPrefetchAbort),
  .reqDataAbort     (reqDataAbort),
  .reqIrq           (reqIrq),
  .reqFiq           (reqFiq),
  .hiVectors        (hiVectors),
  .ctrlWrEn         (ctrlWrEn),
  .take             (take),
  .grant            (grant),
  .vector           (vector),
  .ctrlOut          (ctrlOut)
);

// File: tb/exc_arbiter_bench.sv
module exc_arbiter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  req = '0;     // bit order: reset, undef, swi, pabt, dabt, irq, fiq
  logic        hiVectors = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [7:0]  ctrlWrData = '0;
  logic        take;
  logic [6:0]  grant;
  logic [2:0]  modeCode;
  logic [31:0] vector;
  logic [7:0]  ctrlOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_arbiter u_exc_arbiter (
    .clk              (clk),
    .rstN             (rstN),
    .reqReset         (req[0]),
    .reqUndef         (req[1]),
    .reqSwi           (req[2]),
    .reqPrefetchAbort (req[3]),
    .reqDataAbort     (req[4]),
    .reqIrq           (req[5]),
    .reqFiq           (req[6]),
    .hiVectors        (hiVectors),
    .ctrlWrEn         (ctrlWrEn),
    .ctrlWrData       (ctrlWrData),
    .take             (take),
    .grant            (grant),
    .modeCode         (modeCode),
    .vector           (vector),
    .ctrlOut          (ctrlOut)
  );

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Winner index by the stated priority, -1 if none
  function automatic int pickWinner(logic [6:0] eff);
    int order [7] = '{0, 4, 6, 5, 3, 1, 2};
    for (int i = 0; i < 7; i++) if (eff[order[i]]) return order[i];
    return -1;
  endfunction

  function automatic logic [31:0] expOffset(int k);
    case (k)
      0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
      4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
    endcase
  endfunction

  function automatic logic [2:0] expMode(int k);
    case (k)
      6: return 3'd1; 5: return 3'd2; 0, 2: return 3'd3;
      3, 4: return 3'd4; default: return 3'd5;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0]  expGrant = '0;
    logic [2:0]  expModeQ = '0;
    logic [31:0] expVec = '0;

    // R1: reset state
    repeat (2) @(negedge clk);
    checkVal("R1", "take in reset", 32'(take), 0);
    checkVal("R1", "ctrl in reset", 32'(ctrlOut), 32'hC0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "take after reset", 32'(take), 0);
    checkVal("R1", "grant after reset", 32'(grant), 0);
    checkVal("R1", "mode after reset", 32'(modeCode), 0);
    checkVal("R1", "vector after reset", 32'(vector), 0);
    checkVal("R1", "ctrl after reset", 32'(ctrlOut), 32'hC0);

    // Exhaustive sweep: requests x masks x vector base
    for (int idx = 0; idx < 1024; idx++) begin
      logic [6:0] p   = idx[6:0];
      logic       m7  = idx[7];
      logic       m6  = idx[8];
      logic       hv  = idx[9];
      logic [7:0] wr  = {m7, m6, 6'(idx * 5 + 3)};
      logic [6:0] eff;
      logic [7:0] expCtrl;
      int         win;

      ctrlWrEn = 1'b1; ctrlWrData = wr; req = '0;
      @(negedge clk);
      ctrlWrEn = 1'b0; req = p; hiVectors = hv;
      @(negedge clk);
      req = '0;

      eff = p;
      if (m7) eff[5] = 1'b0;
      if (m6) eff[6] = 1'b0;
      win = pickWinner(eff);
      expCtrl = wr;
      if (win >= 0) begin
        expGrant = 7'(1 << win);
        expModeQ = expMode(win);
        expVec   = (hv ? 32'hFFFF_0000 : 32'h0) | expOffset(win);
        expCtrl[7] = 1'b1;
        if (win == 0 || win == 6) expCtrl[6] = 1'b1;
      end
      checkVal("R9", "take", 32'(take), 32'(win >= 0));
      checkVal("R2/R3/R7", "grant", 32'(grant), 32'(expGrant));
      checkVal("R6", "mode", 32'(modeCode), 32'(expModeQ));
      checkVal("R4", "vector offset", 32'(vector[7:0]), 32'(expVec[7:0]));
      checkVal("R5", "vector base", 32'(vector[31:16]), 32'(expVec[31:16]));
      checkVal("R8", "ctrl after entry", 32'(ctrlOut), 32'(expCtrl));
      @(negedge clk);
      checkVal("R9", "take is one cycle", 32'(take), 0);
    end

    // R10: write and arbitration in the same cycle use the old mask
    ctrlWrEn = 1'b1; ctrlWrData = 8'h80; hiVectors = 1'b0;
    @(negedge clk);
    ctrlWrData = 8'h00; req = 7'b0100000;  // irq, still masked by old byte
    @(negedge clk);
    ctrlWrEn = 1'b0;
    checkVal("R10", "masked irq during write", 32'(take), 0);
    checkVal("R10", "ctrl loaded", 32'(ctrlOut), 32'h00);
    @(negedge clk);  // irq held, now unmasked
    checkVal("R3", "irq take when unmasked", 32'(take), 1);
    checkVal("R4", "irq grant", 32'(grant), 32'h20);
    checkVal("R8", "irq sets bit 7 only", 32'(ctrlOut), 32'h80);
    @(negedge clk);  // irq still held, blocked by the new mask
    req = '0;
    checkVal("R9", "held irq blocked", 32'(take), 0);
    checkVal("R9", "grant holds", 32'(grant), 32'h20);
    checkVal("R9", "vector holds", vector, 32'h18);

    // R10: write plus take in the same cycle ORs the mask on top
    ctrlWrEn = 1'b1; ctrlWrData = 8'h11; req = 7'b0000100; hiVectors = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0; req = '0;
    checkVal("R10", "write plus swi take", 32'(ctrlOut), 32'h91);
    checkVal("R5", "swi high vector", vector, 32'hFFFF_0008);
    checkVal("R6", "swi mode", 32'(modeCode), 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule